// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block sits beside one timer channel and gathers the channel's event pulses: compare or capture matches on general registers A to F, counter overflow and counter underflow. Each event source owns a sticky status flag and an enable bit. A flag that is set and enabled raises the channel interrupt request. An encoded index names the winning source under a fixed priority order. Flag A can also start a DMA transfer.

Software reaches the block through a small register port with two registers. The status register holds the flags, and a flag is cleared by writing 0 to it after it has been read as 1. The enable register holds one enable bit per source plus a DMA activation bit. A parameter selects the seven-source channel variant or the four-source channel variant. Both the register bit order and the priority order follow the slot order of that variant.

Top module: `tmr_irq_flagctl`

## Requirements
- R1: After reset all flags, all enable bits and the DMA activation bit are 0, `irq_valid` is 0 and `dma_req` is 0.
- R2: An event pulse sets its flag at the next clock edge whether or not it is enabled. Status bit k is slot k. For the seven-source variant the slots are: bit0 match A, bit1 match B, bit2 match C, bit3 match D, bit4 overflow, bit5 match E, bit6 match F. For the four-source variant they are: bit0 match A, bit1 match B, bit2 overflow, bit3 underflow. `ev_cmp[5:0]` carries matches A..F on bits 0..5.
- R3: `irq_valid` is 1 exactly when at least one flag and its enable bit are both 1.
- R4: `irq_src` is the lowest slot index whose flag and enable bit are both 1, so slot 0 has the highest priority. The order is fixed.
- R5: Writing 0 to a status bit clears that flag only if a status read (`reg_rd` with `reg_sel`=0) returned that bit as 1 since the last status write touching it. Writing 1 has no effect. Writing 0 without such a read has no effect.
- R6: An event that arrives in the same cycle as a clearing write or a DMA acknowledge leaves its flag set.
- R7: The enable register (`reg_sel`=1) holds the per-slot enable bits in bits [N-1:0] and DMA activation in bit 7. Writing it does not change any flag.
- R8: `dma_req` is a one-cycle pulse in the cycle after a match-A event that finds flag A clear while DMA activation is 1. No other source raises it.
- R9: `dma_ack` clears flag A without a prior read.
- R10: Event inputs with no slot in the chosen variant have no effect. In the four-source variant these are matches C to F. In the seven-source variant this is underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_cmp | input | 6 | Match/capture pulses, registers A..F on bits 0..5 |
| ev_ovf | input | 1 | Counter overflow pulse |
| ev_unf | input | 1 | Counter underflow pulse |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_rd | input | 1 | Read strobe, arms the clear of status bits read as 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| dma_ack | input | 1 | DMA acknowledge, clears flag A |
| irq_valid | output | 1 | Interrupt request |
| irq_src | output | IW | Slot index of the winning source |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The bench builds two copies from the same stimulus. One copy uses the seven-source variant (`SEVEN_SRC`=1) and the other uses the four-source variant (`SEVEN_SRC`=0). A single pulse or enable mask therefore shows both slot maps and both priority orders side by side. Because the inputs are shared, the same stimulus also shows that matches C to F are ignored by the four-source copy while underflow is ignored by the seven-source copy. The expected values for both variants come from the slot tables in the requirements.

// File: rtl/tifc_pkg.sv
package tifc_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned DMA_EN_BIT = 7;

  // lowest set bit index of an 8-bit vector, 0 when empty
  function automatic logic [2:0] first_set(input logic [7:0] v);
    logic [2:0] idx;
    idx = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) idx = 3'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/tifc_flag_bank.sv
module tifc_flag_bank #(
  parameter int unsigned NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            rd_stat,
  input  logic            wr_stat,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] ext_clr,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] clr_hit
);
  logic [NSRC-1:0] arm_q, arm_d, flag_d, clr_sw;

  always_comb begin
    clr_sw  = wr_stat ? (~wdata & arm_q) : '0;
    clr_hit = clr_sw | ext_clr;
    flag_d  = (flag_q & ~clr_hit) | evt;
    arm_d   = arm_q;
    if (rd_stat) arm_d = arm_d | flag_q;
    if (wr_stat) arm_d = arm_d & wdata;
    arm_d   = arm_d & flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R2 / R6: an event always leaves its flag set
    a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag_q[i]);
    // R5: a flag only drops after an armed zero-write or an acknowledge
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_hit[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/tifc_prio_enc.sv
module tifc_prio_enc #(
  parameter int unsigned NSRC = 7,
  parameter int unsigned IW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] en,
  output logic            valid,
  output logic [IW-1:0]   src
);
  import tifc_pkg::*;
  logic [NSRC-1:0] active;
  logic [2:0]      win;

  always_comb begin
    active = flag & en;
    win    = first_set(8'(active));
    valid  = |active;
    src    = IW'(win);
  end

  // R4: the reported source is a live request
  a_r4_src_live: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (flag[src] && en[src]));
  // R4: no higher-priority request is being skipped
  a_r4_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((flag & en & NSRC'((1 << src) - 1)) == '0));
  // R3: no request is reported while nothing is enabled and set
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & en) == '0) |-> !valid);
endmodule

// File: rtl/tifc_dma_req.sv
module tifc_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_a,
  input  logic flag_a,
  input  logic dma_en,
  output logic dreq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_q <= 1'b0;
    else        dreq_q <= evt_a & ~flag_a & dma_en;
  end

  // R8: a request is never longer than one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q |=> !dreq_q);
  // R8: a request only accompanies a freshly set flag A
  a_r8_from_a: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q |-> flag_a);
endmodule

// File: rtl/tmr_irq_flagctl.sv
module tmr_irq_flagctl #(
  parameter bit SEVEN_SRC = 1'b1,
  localparam int unsigned NSRC = SEVEN_SRC ? 7 : 4,
  localparam int unsigned IW   = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    ev_cmp,
  input  logic          ev_ovf,
  input  logic          ev_unf,
  input  logic          reg_sel,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          dma_ack,
  output logic          irq_valid,
  output logic [IW-1:0] irq_src,
  output logic          dma_req
);
  import tifc_pkg::*;

  logic [NSRC-1:0] evt_slot, flag_q, en_q, clr_hit, ext_clr;
  logic            dma_en_q;
  logic            rd_stat, wr_stat, wr_en;

  // slot map: index order is priority order
  if (SEVEN_SRC) begin : g_seven
    assign evt_slot = {ev_cmp[5], ev_cmp[4], ev_ovf, ev_cmp[3:0]};
  end else begin : g_four
    assign evt_slot = {ev_unf, ev_ovf, ev_cmp[1:0]};
  end

  assign rd_stat = reg_rd & ~reg_sel;
  assign wr_stat = reg_wr & ~reg_sel;
  assign wr_en   = reg_wr & reg_sel;
  assign ext_clr = NSRC'(dma_ack);

  tifc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_slot),
    .rd_stat(rd_stat), .wr_stat(wr_stat), .wdata(reg_wdata[NSRC-1:0]),
    .ext_clr(ext_clr), .flag_q(flag_q), .clr_hit(clr_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      dma_en_q <= 1'b0;
    end else if (wr_en) begin
      en_q     <= reg_wdata[NSRC-1:0];
      dma_en_q <= reg_wdata[DMA_EN_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[NSRC-1:0]   = en_q;
      reg_rdata[DMA_EN_BIT] = dma_en_q;
    end else begin
      reg_rdata[NSRC-1:0]   = flag_q;
    end
  end

  tifc_prio_enc #(.NSRC(NSRC), .IW(IW)) u_enc (
    .clk(clk), .rst_n(rst_n), .flag(flag_q), .en(en_q),
    .valid(irq_valid), .src(irq_src)
  );

  tifc_dma_req u_dma (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_slot[0]), .flag_a(flag_q[0]),
    .dma_en(dma_en_q), .dreq_q(dma_req)
  );

  // R7: an enable write alone leaves the flags untouched
  a_r7_en_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && evt_slot == '0 && !dma_ack) |=> $stable(flag_q));
  // R9: acknowledge without a new event drops flag A
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !evt_slot[0]) |=> !flag_q[0]);
  // R5: a status write of all ones never clears anything
  a_r5_wr1_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (&reg_wdata[NSRC-1:0]) && !dma_ack) |-> (clr_hit == '0));
endmodule

// File: tb/sim_tmr_irq_flagctl.sv
module sim_tmr_irq_flagctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ev_cmp = '0;
  logic ev_ovf = 1'b0, ev_unf = 1'b0;
  logic reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0, dma_ack = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd0, rd1;
  logic v0, v1, dq0, dq1;
  logic [2:0] s0;
  logic [1:0] s1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_flagctl #(.SEVEN_SRC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_cmp(ev_cmp), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd0), .dma_ack(dma_ack), .irq_valid(v0), .irq_src(s0), .dma_req(dq0));

  tmr_irq_flagctl #(.SEVEN_SRC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .ev_cmp(ev_cmp), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd1), .dma_ack(dma_ack), .irq_valid(v1), .irq_src(s1), .dma_req(dq1));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_cmp = '0; ev_ovf = 0; ev_unf = 0;
    reg_rd = 0; reg_wr = 0; dma_ack = 0; reg_sel = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse(input logic [5:0] c, input logic o, input logic u);
    ev_cmp = c; ev_ovf = o; ev_unf = u;
    tick();
    ev_cmp = '0; ev_ovf = 0; ev_unf = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_arm();
    reg_sel = 0; reg_rd = 1;
    tick();
    reg_rd = 0;
  endtask

  task automatic stat(input string req, input int e0, input int e1);
    reg_sel = 0; #1;
    chk(req, rd0, e0); chk(req, rd1, e1);
  endtask

  task automatic t_reset();
    do_reset();
    stat("R1 status", 0, 0);
    reg_sel = 1; #1;
    chk("R1 enable7", rd0, 0); chk("R1 enable4", rd1, 0);
    chk("R1 irq", {v0, v1}, 0); chk("R1 dreq", {dq0, dq1}, 0);
  endtask

  task automatic t_slots();
    do_reset();
    pulse(6'h00, 1, 0);
    stat("R2 overflow slot", 8'h10, 8'h04);
    pulse(6'h00, 0, 1);
    stat("R10 underflow", 8'h10, 8'h0C);
    pulse(6'h04, 0, 0);
    stat("R10 match C", 8'h14, 8'h0C);
    pulse(6'h3F, 1, 1);
    stat("R2 all sources", 8'h7F, 8'h0F);
    chk("R3 no enable no irq", {v0, v1}, 0);
  endtask

  task automatic prio(input logic [7:0] m, input int ev0, input int es0,
                      input int ev1, input int es1);
    wr(1, m); #1;
    chk("R3 valid7", v0, ev0); chk("R3 valid4", v1, ev1);
    if (ev0 != 0) chk("R4 src7", s0, es0);
    if (ev1 != 0) chk("R4 src4", s1, es1);
  endtask

  task automatic t_priority();
    do_reset();
    pulse(6'h3F, 1, 1);
    prio(8'h7F, 1, 0, 1, 0);
    prio(8'h7E, 1, 1, 1, 1);
    prio(8'h7C, 1, 2, 1, 2);
    prio(8'h70, 1, 4, 0, 0);
    prio(8'h60, 1, 5, 0, 0);
    prio(8'h48, 1, 3, 1, 3);
    prio(8'h40, 1, 6, 0, 0);
    reg_sel = 1; #1;
    chk("R7 enable readback7", rd0, 8'h40); chk("R7 enable readback4", rd1, 8'h00);
    stat("R7 flags kept", 8'h7F, 8'h0F);
  endtask

  task automatic t_clear();
    do_reset();
    wr(1, 8'h03);
    pulse(6'h03, 0, 0);
    stat("R2 A B set", 8'h03, 8'h03);
    wr(0, 8'h00);
    stat("R5 no read no clear", 8'h03, 8'h03);
    rd_arm();
    wr(0, 8'hFE);
    stat("R5 clear A", 8'h02, 8'h02);
    chk("R4 B wins", {1'b0, s0, 2'b0, s1}, {4'd1, 4'd1});
    wr(0, 8'hFF);
    stat("R5 write one", 8'h02, 8'h02);
    wr(0, 8'h00);
    stat("R5 clear B", 8'h00, 8'h00);
    chk("R3 irq drops", {v0, v1}, 0);
  endtask

  task automatic t_race();
    do_reset();
    pulse(6'h01, 0, 0);
    rd_arm();
    ev_cmp = 6'h01; reg_sel = 0; reg_wdata = 8'h00; reg_wr = 1;
    tick();
    ev_cmp = '0; reg_wr = 0;
    stat("R6 event beats clear", 8'h01, 8'h01);
    wr(0, 8'h00);
    stat("R5 arm consumed", 8'h01, 8'h01);
    rd_arm();
    wr(0, 8'h00);
    stat("R5 rearmed clear", 8'h00, 8'h00);
  endtask

  task automatic t_dma();
    do_reset();
    wr(1, 8'h80);
    stat("R7 flags kept", 0, 0);
    pulse(6'h01, 0, 0);
    chk("R8 dreq pulse", {dq0, dq1}, 2'b11);
    tick();
    chk("R8 dreq one cycle", {dq0, dq1}, 0);
    pulse(6'h01, 0, 0);
    chk("R8 no dreq flag set", {dq0, dq1}, 0);
    dma_ack = 1; tick(); dma_ack = 0;
    stat("R9 ack clears A", 0, 0);
    ev_cmp = 6'h01; dma_ack = 1; tick(); ev_cmp = '0; dma_ack = 0;
    stat("R6 event beats ack", 8'h01, 8'h01);
    chk("R8 dreq with ack", {dq0, dq1}, 2'b11);
    dma_ack = 1; tick(); dma_ack = 0;
    pulse(6'h02, 0, 0);
    chk("R8 B no dreq", {dq0, dq1}, 0);
    wr(1, 8'h00);
    pulse(6'h01, 0, 0);
    chk("R8 dma disabled", {dq0, dq1}, 0);
    stat("R2 flags", 8'h03, 8'h03);
  endtask

  initial begin
    t_reset();
    t_slots();
    t_priority();
    t_clear();
    t_race();
    t_dma();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule